// File: doc/BRIEF.md
# Sequential-Code Histogram Counter

This block is the response analyser of an on-chip converter self-test. A sine stimulus drives the converter, and the block builds the code histogram one bin at a time. It holds a target code and watches a fixed window of valid converter samples. It counts the samples whose word equals the target, then reports that count and moves on to the next code. A full sweep covers every code from zero to the top of the resolution.

Only one hit register is kept. A pass over all codes therefore costs 2^N windows of stimulus instead of one window with a bin per code. In exchange, the storage stays a few counters wide whatever the resolution. A test sequencer asserts start, streams samples with a valid strobe, and collects one result per `code_done_o` pulse until `done_o` rises.

Top module: `hist_seq_counter`

## Requirements
- R1: While synchronous reset is high, and on the cycle after it, all outputs are zero: target code 0, no result pulse, done low, result code and count 0.
- R2: A start pulse clears the target code, the window position and the hit count to zero, and drops done. This holds during a sweep as well. A sample presented in the same cycle as start is not counted.
- R3: A sample is taken only in a cycle with `sample_valid_i` high while a sweep is running. Words in cycles with the strobe low have no effect on any count.
- R4: A sample is a hit only when the whole `ADC_W`-bit word equals the target code zero-extended to `ADC_W` bits. A word that differs only in bits above `CODE_W` is not a hit.
- R5: After every `WIN` taken samples, `code_done_o` is high for one cycle. `res_code_o` then gives the code just finished and `res_count_o` gives the hits among exactly those `WIN` samples. The next code's count starts from zero.
- R6: Target codes are visited in ascending order, 0, 1, ..., 2^CODE_W−1, each exactly once per sweep.
- R7: `done_o` rises in the same cycle as the result pulse of code 2^CODE_W−1. It stays high, with `cur_code_o` held at that last code, and later valid samples produce no result pulse until start.
- R8: `res_count_o` never exceeds `WIN`. It is `ceil(log2(WIN+1))` bits wide, so a window of all hits reports exactly `WIN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin (or restart) a sweep at code 0 |
| sample_valid_i | input | 1 | Converter word on `adc_i` is a sample |
| adc_i | input | ADC_W | Converter output word |
| cur_code_o | output | CODE_W | Target code currently being counted |
| code_done_o | output | 1 | One-cycle pulse: a code's window finished |
| res_code_o | output | CODE_W | Code whose result is reported |
| res_count_o | output | CNT_W | Hits of that code in its window |
| done_o | output | 1 | Sweep over all codes finished |

## Verification
The bench keeps the converter word at its full 13 bits but uses `CODE_W = 3` and `WIN = 5`. With these values a whole sweep is only 40 taken samples, so two complete sweeps and an aborted one fit in a short run. With the full 13-bit word, the bench can present words that match the target in the low bits but carry a high bit set. With a five-sample window, the per-code counts can cover every value from zero hits up to a full window of hits.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic {
    SW_IDLE = 1'b0,
    SW_RUN  = 1'b1
  } sweep_st_e;
endpackage

// File: rtl/hist_sweep_ctrl.sv
module hist_sweep_ctrl #(
  parameter int CODE_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wrap,
  output logic [CODE_W-1:0] code,
  output logic              busy,
  output logic              done
);
  import hist_pkg::*;

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  sweep_st_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= SW_IDLE;
      code <= '0;
      done <= 1'b0;
    end else if (start) begin
      st_q <= SW_RUN;
      code <= '0;
      done <= 1'b0;
    end else if (st_q == SW_RUN && wrap) begin
      if (code == CODE_MAX) begin
        st_q <= SW_IDLE;
        done <= 1'b1;
      end else begin
        code <= code + 1'b1;
      end
    end
  end

  assign busy = (st_q == SW_RUN);
endmodule

// File: rtl/hist_window_cnt.sv
module hist_window_cnt #(
  parameter int WIN = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic samp_en,
  output logic wrap
);
  localparam int SAMP_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [SAMP_W-1:0] LAST = SAMP_W'(WIN - 1);

  logic [SAMP_W-1:0] pos_q;

  assign wrap = samp_en && (pos_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      pos_q <= '0;
    end else if (samp_en) begin
      pos_q <= wrap ? '0 : pos_q + 1'b1;
    end
  end
endmodule

// File: rtl/hist_hit_acc.sv
module hist_hit_acc #(
  parameter int CODE_W = 13,
  parameter int WIN    = 64,
  parameter int CNT_W  = $clog2(WIN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              samp_en,
  input  logic              wrap,
  input  logic              match,
  input  logic [CODE_W-1:0] code,
  output logic              res_valid,
  output logic [CODE_W-1:0] res_code,
  output logic [CNT_W-1:0]  res_count
);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(WIN);

  logic [CNT_W-1:0] hits_q;
  logic [CNT_W-1:0] hits_nxt;

  always_comb begin
    hits_nxt = hits_q;
    if (match && hits_q != CNT_LIM) hits_nxt = hits_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hits_q    <= '0;
      res_valid <= 1'b0;
      res_code  <= '0;
      res_count <= '0;
    end else begin
      res_valid <= 1'b0;
      if (start) begin
        hits_q <= '0;
      end else if (samp_en) begin
        if (wrap) begin
          res_valid <= 1'b1;
          res_code  <= code;
          res_count <= hits_nxt;
          hits_q    <= '0;
        end else begin
          hits_q <= hits_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/hist_seq_counter.sv
module hist_seq_counter #(
  parameter int ADC_W  = 13,
  parameter int CODE_W = 13,
  parameter int WIN    = 64,
  parameter int CNT_W  = $clog2(WIN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              sample_valid_i,
  input  logic [ADC_W-1:0]  adc_i,
  output logic [CODE_W-1:0] cur_code_o,
  output logic              code_done_o,
  output logic [CODE_W-1:0] res_code_o,
  output logic [CNT_W-1:0]  res_count_o,
  output logic              done_o
);
  logic busy;
  logic samp_en;
  logic wrap;
  logic match;

  assign samp_en = busy && sample_valid_i && !start_i;
  assign match   = (adc_i == ADC_W'(cur_code_o));

  hist_sweep_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start_i),
    .wrap  (wrap),
    .code  (cur_code_o),
    .busy  (busy),
    .done  (done_o)
  );

  hist_window_cnt #(.WIN(WIN)) u_win (
    .clk     (clk),
    .rst     (rst),
    .start   (start_i),
    .samp_en (samp_en),
    .wrap    (wrap)
  );

  hist_hit_acc #(.CODE_W(CODE_W), .WIN(WIN), .CNT_W(CNT_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .start     (start_i),
    .samp_en   (samp_en),
    .wrap      (wrap),
    .match     (match),
    .code      (cur_code_o),
    .res_valid (code_done_o),
    .res_code  (res_code_o),
    .res_count (res_count_o)
  );
endmodule

// File: rtl/hist_seq_counter_chk.sv
module hist_seq_counter_chk #(
  parameter int CODE_W = 13,
  parameter int WIN    = 64,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [CODE_W-1:0] cur_code_o,
  input logic              code_done_o,
  input logic [CODE_W-1:0] res_code_o,
  input logic [CNT_W-1:0]  res_count_o,
  input logic              done_o
);
  localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (cur_code_o == '0 && !done_o && !code_done_o));

  // R5
  result_code_chk: assert property (@(posedge clk) disable iff (rst)
    code_done_o |-> (res_code_o == $past(cur_code_o)));

  // R6
  code_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_code_o != $past(cur_code_o)) |-> (code_done_o || $past(start_i)));

  // R7
  done_with_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> (code_done_o && res_code_o == CODE_TOP));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> (done_o && !code_done_o && $stable(cur_code_o)));

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    res_count_o <= CNT_W'(WIN));
endmodule

bind hist_seq_counter hist_seq_counter_chk #(
  .CODE_W(CODE_W), .WIN(WIN), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .cur_code_o  (cur_code_o),
  .code_done_o (code_done_o),
  .res_code_o  (res_code_o),
  .res_count_o (res_count_o),
  .done_o      (done_o)
);

// File: tb/hist_seq_counter_test.sv
module hist_seq_counter_test;
  localparam int ADC_W  = 13;
  localparam int CODE_W = 3;
  localparam int WIN    = 5;
  localparam int CNT_W  = $clog2(WIN + 1);
  localparam int NCODES = 1 << CODE_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic              sample_valid_i = 1'b0;
  logic [ADC_W-1:0]  adc_i = '0;
  logic [CODE_W-1:0] cur_code_o;
  logic              code_done_o;
  logic [CODE_W-1:0] res_code_o;
  logic [CNT_W-1:0]  res_count_o;
  logic              done_o;

  int checks = 0;
  int errors = 0;
  int exp_q[$];

  int m_code = 0;
  int m_pos  = 0;
  int m_hits = 0;
  bit m_busy = 0;

  always #10 clk = ~clk;

  hist_seq_counter #(.ADC_W(ADC_W), .CODE_W(CODE_W), .WIN(WIN)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .sample_valid_i(sample_valid_i),
    .adc_i(adc_i), .cur_code_o(cur_code_o), .code_done_o(code_done_o),
    .res_code_o(res_code_o), .res_count_o(res_count_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes expected results.
  task automatic drive(input bit st, input bit vl, input int w);
    @(negedge clk);
    start_i = st;
    sample_valid_i = vl;
    adc_i = ADC_W'(w);
    if (st) begin
      m_busy = 1; m_code = 0; m_pos = 0; m_hits = 0;
    end else if (vl && m_busy) begin
      if (w == m_code && m_hits < WIN) m_hits++;
      if (m_pos == WIN - 1) begin
        exp_q.push_back(m_code * 256 + m_hits);
        m_pos = 0; m_hits = 0;
        if (m_code == NCODES - 1) m_busy = 0;
        else m_code++;
      end else begin
        m_pos++;
      end
    end
  endtask

  task automatic settle();
    @(posedge clk);
    #5;
  endtask

  // Monitor: compares each result pulse with the scoreboard.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (!rst && code_done_o) begin
        if (exp_q.size() == 0) begin
          chk(0, "R7 unexpected code_done", 1, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(res_code_o) == e / 256, "R6 result code", res_code_o, e / 256);
          chk(int'(res_count_o) == e % 256, "R5 result count", res_count_o, e % 256);
          chk(int'(res_count_o) <= WIN, "R8 count bound", res_count_o, WIN);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk(cur_code_o == 0 && !code_done_o && !done_o && res_count_o == 0 && res_code_o == 0,
        "R1 reset state", {cur_code_o, code_done_o, done_o}, 0);
    @(negedge clk);
    rst = 1'b0;
    settle();
    chk(cur_code_o == 0 && !done_o, "R1 after reset", cur_code_o, 0);

    // R3: samples before any start are ignored
    for (int i = 0; i < 2 * WIN; i++) drive(0, 1, 0);
    drive(0, 0, 0);
    settle();
    chk(cur_code_o == 0 && !done_o, "R3 idle ignores samples", cur_code_o, 0);

    // Sweep 1: c % (WIN+1) hits per code, with distractors (R4) and invalid cycles (R3)
    drive(1, 0, 0);
    for (int c = 0; c < NCODES; c++) begin
      for (int s = 0; s < WIN; s++) begin
        int nm;
        nm = c % (WIN + 1);
        drive(0, 0, c);
        if (s < nm) drive(0, 1, c);
        else if (s % 2 == 0) drive(0, 1, c | 13'h1000);
        else drive(0, 1, (c + 1) % NCODES);
      end
    end
    drive(0, 0, 0);
    settle();
    chk(done_o == 1, "R7 done after sweep", done_o, 1);
    chk(cur_code_o == NCODES - 1, "R7 code held at last", cur_code_o, NCODES - 1);
    chk(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);

    // R7: samples after done are ignored
    for (int i = 0; i < WIN + 1; i++) drive(0, 1, NCODES - 1);
    drive(0, 0, 0);
    settle();
    chk(done_o == 1 && cur_code_o == NCODES - 1, "R7 done holds", done_o, 1);

    // R2: restart mid-sweep, start wins over a same-cycle sample
    drive(1, 0, 0);
    for (int i = 0; i < 2 * WIN + 2; i++) drive(0, 1, i % 3);
    drive(1, 1, 0);
    drive(0, 0, 0);
    settle();
    chk(cur_code_o == 0 && !done_o, "R2 restart clears", cur_code_o, 0);

    // Sweep 2: every sample hits, count must reach WIN exactly (R8)
    for (int c = 0; c < NCODES; c++)
      for (int s = 0; s < WIN; s++) drive(0, 1, c);
    drive(0, 0, 0);
    settle();
    chk(done_o == 1, "R7 done after second sweep", done_o, 1);
    chk(exp_q.size() == 0, "R5 second sweep results seen", exp_q.size(), 0);

    repeat (2) settle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule